// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the read and write strobes for programmed-I/O transfers on a parallel ATA host port. A requester presents an access with a device select (master or slave), a cycle kind (16-bit data port or 8-bit taskfile register) and a direction. The block picks the matching strobe-width and recovery counts from its timing registers and drives the active-low read or write strobe for the programmed number of controller clocks. It then holds the strobe inactive for the recovery time before it takes the next access.

Each timing register packs two byte lanes, one per device. Every field uses a minus-one encoding. The device's ready line can stretch the strobe while it is held low. A programmable timeout bounds the stretch. When the timeout runs out, the cycle is forced to end and a sticky flag is recorded. Software sets the timing through a small register port. The reset values already give the slowest transfer timing, a 600 ns cycle, for both devices. Cycles start only after the enable bit has been written.

Top module: `pio_timing_gen`

## Requirements
- R1: Bits [7:0] of every timing register apply to device 0 and bits [15:8] to device 1. `reqDev` picks the lane for each access.
- R2: With `ataIordy` high, a strobe field value N keeps the strobe asserted for exactly N+1 clocks, starting the clock after the request is accepted.
- R3: A recovery field value M keeps both strobes inactive for M+1 clocks. A request held valid is accepted back to back, so consecutive strobe assertions start exactly N+M+2 clocks apart, and never sooner.
- R4: `reqIsData`=1 uses the data-port pair (strobe at address 1, recovery at address 2). `reqIsData`=0 uses the taskfile pair (strobe at 3, recovery at 4).
- R5: A register write changes only the byte lanes whose `cfgBe` bit is set (`cfgBe[0]` = bits [7:0], `cfgBe[1]` = bits [15:8]). The other lane keeps its value.
- R6: After reset, control (address 0) reads 0 and the timeout (address 5) reads 0xFFFF. Each lane of the data pair and of the taskfile pair holds the slowest timing for a 600 ns cycle: with the strobe rounded up from 165 ns (data) or 290 ns (taskfile), strobe = ceil(act/CLK_NS)-1 and recovery = ceil(600/CLK_NS)-ceil(act/CLK_NS)-1.
- R7: While control bit 15 (enable) is 0, no request is accepted. No strobe asserts and `reqAck` stays low.
- R8: Each clock in which `ataIordy` is sampled low during the strobe freezes the strobe count, which lengthens the strobe by one clock.
- R9: If `ataIordy` stays low with timeout value T, the strobe ends after T+1 clocks and control bit 0 becomes 1. Bit 0 stays set until a write with `cfgBe[0]`=1 and data bit 0 = 1. If that write lands in the same clock as a new timeout, the flag stays set.
- R10: `reqAck` is high for exactly one clock, the first clock in which the strobe is inactive again. At that point `reqRdata` holds `ataDin` as sampled on the edge that ended the strobe.
- R11: A read asserts only `ataRdN` and a write asserts only `ataWrN`. During a write, `ataDout` carries `reqWdata` and `ataDoe` is high while the strobe is active.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address: 0 control, 1/2 data strobe/recovery, 3/4 taskfile strobe/recovery, 5 timeout |
| cfgBe | input | 2 | Byte-lane enables for writes |
| cfgWdata | input | 16 | Register write data |
| cfgRdata | output | 16 | Register read data for `cfgAddr` (combinational) |
| reqValid | input | 1 | Access request |
| reqDev | input | 1 | Device select: 0 master, 1 slave |
| reqIsData | input | 1 | 1 = 16-bit data port, 0 = taskfile register |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write data |
| reqAck | output | 1 | One-clock completion pulse |
| reqRdata | output | 16 | Captured read data |
| ataRdN | output | 1 | Active-low read strobe |
| ataWrN | output | 1 | Active-low write strobe |
| ataIordy | input | 1 | Device ready; low stretches the strobe |
| ataDin | input | 16 | Device data bus in |
| ataDout | output | 16 | Device data bus out |
| ataDoe | output | 1 | Data bus output enable |

## Verification
Two functions can fall in the same clock: the timeout setting the sticky flag, and a software write that clears it. The bench holds the ready line low with a small timeout, so the bench knows the exact clock in which the forced end happens. It issues the clearing write in that same clock. It then reads control and expects bit 0 still set. A second run clears the flag at a different time and expects bit 0 to go to 0. A further pair of events is checked in the back-to-back sweeps: the end of recovery coincides with the acceptance of the next request. The strobe-to-strobe spacing is compared against N+M+2.

// File: rtl/pio_timing_pkg.sv
`timescale 1ns/1ps
package pio_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STROBE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // accept request, load strobe and timeout counts
    logic loadRcv;    // load recovery count
    logic decCnt;     // decrement phase count
    logic decTmo;     // decrement ready timeout
    logic capture;    // capture read data
    logic setTmo;     // raise sticky timeout flag
  } pio_ctl_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DSTB = 3'd1;
  localparam logic [2:0] ADDR_DRCV = 3'd2;
  localparam logic [2:0] ADDR_TSTB = 3'd3;
  localparam logic [2:0] ADDR_TRCV = 3'd4;
  localparam logic [2:0] ADDR_TMO  = 3'd5;

  localparam int SLOW_CYCLE_NS  = 600;
  localparam int SLOW_DACT_NS   = 165;
  localparam int SLOW_TACT_NS   = 290;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/pio_timing_dpath.sv
`timescale 1ns/1ps
module pio_timing_dpath
  import pio_timing_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [1:0]           cfgBe,
  input  logic [2*FIELD_W-1:0] cfgWdata,
  output logic [2*FIELD_W-1:0] cfgRdata,
  input  logic                 reqDev,
  input  logic                 reqIsData,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    ataDin,
  input  pio_ctl_t             ctl,
  output logic [DATA_W-1:0]    reqRdata,
  output logic [DATA_W-1:0]    ataDout,
  output logic                 cntZero,
  output logic                 tmoZero,
  output logic                 enFlag,
  output logic                 stickyFlag,
  output logic                 curWrite
);
  localparam int CFG_W = 2 * FIELD_W;

  localparam int D_STB_I = ceilDiv(SLOW_DACT_NS, CLK_NS) - 1;
  localparam int D_RCV_I = ceilDiv(SLOW_CYCLE_NS, CLK_NS) - ceilDiv(SLOW_DACT_NS, CLK_NS) - 1;
  localparam int T_STB_I = ceilDiv(SLOW_TACT_NS, CLK_NS) - 1;
  localparam int T_RCV_I = ceilDiv(SLOW_CYCLE_NS, CLK_NS) - ceilDiv(SLOW_TACT_NS, CLK_NS) - 1;

  localparam logic [FIELD_W-1:0] D_STB_F = FIELD_W'(D_STB_I);
  localparam logic [FIELD_W-1:0] D_RCV_F = FIELD_W'(D_RCV_I);
  localparam logic [FIELD_W-1:0] T_STB_F = FIELD_W'(T_STB_I);
  localparam logic [FIELD_W-1:0] T_RCV_F = FIELD_W'(T_RCV_I);

  logic [CFG_W-1:0]   dStb, dRcv, tStb, tRcv, tmoReg;
  logic [FIELD_W-1:0] phaseCnt;
  logic [CFG_W-1:0]   tmoCnt;
  logic               curDev, curIsData;
  logic               clrSticky;

  function automatic logic [FIELD_W-1:0] pickLane(input logic [CFG_W-1:0] r, input logic dev);
    return dev ? r[CFG_W-1:FIELD_W] : r[FIELD_W-1:0];
  endfunction

  function automatic logic [CFG_W-1:0] laneMerge(input logic [CFG_W-1:0] oldV,
                                                  input logic [CFG_W-1:0] newV,
                                                  input logic [1:0]       be);
    logic [CFG_W-1:0] res;
    res = oldV;
    for (int i = 0; i < 2; i++) begin
      if (be[i]) res[i*FIELD_W +: FIELD_W] = newV[i*FIELD_W +: FIELD_W];
    end
    return res;
  endfunction

  assign clrSticky = cfgWe && (cfgAddr == ADDR_CTRL) && cfgBe[0] && cfgWdata[0];

  // timing registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dStb   <= {D_STB_F, D_STB_F};
      dRcv   <= {D_RCV_F, D_RCV_F};
      tStb   <= {T_STB_F, T_STB_F};
      tRcv   <= {T_RCV_F, T_RCV_F};
      tmoReg <= '1;
      enFlag <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_CTRL: if (cfgBe[1]) enFlag <= cfgWdata[CFG_W-1];
        ADDR_DSTB: dStb   <= laneMerge(dStb, cfgWdata, cfgBe);
        ADDR_DRCV: dRcv   <= laneMerge(dRcv, cfgWdata, cfgBe);
        ADDR_TSTB: tStb   <= laneMerge(tStb, cfgWdata, cfgBe);
        ADDR_TRCV: tRcv   <= laneMerge(tRcv, cfgWdata, cfgBe);
        ADDR_TMO:  tmoReg <= laneMerge(tmoReg, cfgWdata, cfgBe);
        default: ;
      endcase
    end
  end

  // sticky timeout: a new timeout wins over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN)            stickyFlag <= 1'b0;
    else if (ctl.setTmo)  stickyFlag <= 1'b1;
    else if (clrSticky)   stickyFlag <= 1'b0;
  end

  always_comb begin
    case (cfgAddr)
      ADDR_CTRL: cfgRdata = {enFlag, {(CFG_W-2){1'b0}}, stickyFlag};
      ADDR_DSTB: cfgRdata = dStb;
      ADDR_DRCV: cfgRdata = dRcv;
      ADDR_TSTB: cfgRdata = tStb;
      ADDR_TRCV: cfgRdata = tRcv;
      ADDR_TMO:  cfgRdata = tmoReg;
      default:   cfgRdata = '0;
    endcase
  end

  // access context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDev    <= 1'b0;
      curIsData <= 1'b0;
      curWrite  <= 1'b0;
      ataDout   <= '0;
    end else if (ctl.latchReq) begin
      curDev    <= reqDev;
      curIsData <= reqIsData;
      curWrite  <= reqWrite;
      ataDout   <= reqWdata;
    end
  end

  // phase and ready-timeout counters
  always_ff @(posedge clk) begin
    if (!rstN)              phaseCnt <= '0;
    else if (ctl.latchReq)  phaseCnt <= pickLane(reqIsData ? dStb : tStb, reqDev);
    else if (ctl.loadRcv)   phaseCnt <= pickLane(curIsData ? dRcv : tRcv, curDev);
    else if (ctl.decCnt)    phaseCnt <= phaseCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tmoCnt <= '0;
    else if (ctl.latchReq)  tmoCnt <= tmoReg;
    else if (ctl.decTmo)    tmoCnt <= tmoCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             reqRdata <= '0;
    else if (ctl.capture)  reqRdata <= ataDin;
  end

  assign cntZero = (phaseCnt == '0);
  assign tmoZero = (tmoCnt == '0);

endmodule

// File: rtl/pio_timing_ctrl.sv
`timescale 1ns/1ps
module pio_timing_ctrl
  import pio_timing_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     ataIordy,
  input  logic     cntZero,
  input  logic     tmoZero,
  input  logic     enFlag,
  input  logic     curWrite,
  output pio_ctl_t ctl,
  output logic     reqAck,
  output logic     ataRdN,
  output logic     ataWrN,
  output logic     ataDoe,
  output logic     busy
);
  phase_e phase, nextPhase;
  logic   accept, endStrobe;

  always_comb begin
    ctl       = '0;
    nextPhase = phase;
    endStrobe = 1'b0;
    accept    = reqValid && enFlag &&
                ((phase == PH_IDLE) || ((phase == PH_RECOVER) && cntZero));
    case (phase)
      PH_IDLE: begin
        if (accept) nextPhase = PH_STROBE;
      end
      PH_STROBE: begin
        if (!ataIordy) begin
          if (tmoZero) begin
            endStrobe  = 1'b1;
            ctl.setTmo = 1'b1;
          end else begin
            ctl.decTmo = 1'b1;
          end
        end else if (cntZero) begin
          endStrobe = 1'b1;
        end else begin
          ctl.decCnt = 1'b1;
        end
        if (endStrobe) nextPhase = PH_RECOVER;
      end
      PH_RECOVER: begin
        if (cntZero) nextPhase = accept ? PH_STROBE : PH_IDLE;
        else         ctl.decCnt = 1'b1;
      end
      default: nextPhase = PH_IDLE;
    endcase
    ctl.latchReq = accept;
    ctl.loadRcv  = endStrobe;
    ctl.capture  = endStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      reqAck <= 1'b0;
    end else begin
      phase  <= nextPhase;
      reqAck <= endStrobe;
    end
  end

  assign ataRdN = !((phase == PH_STROBE) && !curWrite);
  assign ataWrN = !((phase == PH_STROBE) && curWrite);
  assign ataDoe = (phase == PH_STROBE) && curWrite;
  assign busy   = (phase != PH_IDLE);

endmodule

// File: rtl/pio_timing_gen.sv
`timescale 1ns/1ps
module pio_timing_gen
  import pio_timing_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [1:0]           cfgBe,
  input  logic [2*FIELD_W-1:0] cfgWdata,
  output logic [2*FIELD_W-1:0] cfgRdata,
  input  logic                 reqValid,
  input  logic                 reqDev,
  input  logic                 reqIsData,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqAck,
  output logic [DATA_W-1:0]    reqRdata,
  output logic                 ataRdN,
  output logic                 ataWrN,
  input  logic                 ataIordy,
  input  logic [DATA_W-1:0]    ataDin,
  output logic [DATA_W-1:0]    ataDout,
  output logic                 ataDoe
);
  pio_ctl_t ctl;
  logic     cntZero, tmoZero, enFlag, stickyFlag, curWrite, busy;

  pio_timing_dpath #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS)) u_dpath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqDev(reqDev), .reqIsData(reqIsData), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ataDin(ataDin), .ctl(ctl), .reqRdata(reqRdata), .ataDout(ataDout),
    .cntZero(cntZero), .tmoZero(tmoZero), .enFlag(enFlag),
    .stickyFlag(stickyFlag), .curWrite(curWrite)
  );

  pio_timing_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ataIordy(ataIordy),
    .cntZero(cntZero), .tmoZero(tmoZero), .enFlag(enFlag), .curWrite(curWrite),
    .ctl(ctl), .reqAck(reqAck), .ataRdN(ataRdN), .ataWrN(ataWrN),
    .ataDoe(ataDoe), .busy(busy)
  );

endmodule

// File: rtl/pio_timing_chk.sv
`timescale 1ns/1ps
module pio_timing_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [2:0]       cfgAddr,
  input logic [1:0]       cfgBe,
  input logic [CFG_W-1:0] cfgWdata,
  input logic [CFG_W-1:0] cfgRdata,
  input logic             reqAck,
  input logic             ataRdN,
  input logic             ataWrN,
  input logic             stickyFlag,
  input logic             enFlag,
  input logic             busy
);
  localparam int HALF = CFG_W / 2;

  // R11: never both strobes
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataRdN && !ataWrN));

  // R10: single-clock acknowledge
  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R10: acknowledge sits in the first inactive clock after a strobe
  a_r10_ack_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (ataRdN && ataWrN && (!$past(ataRdN) || !$past(ataWrN))));

  // R7: idle and disabled means no strobe next clock
  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enFlag) |=> (ataRdN && ataWrN));

  // R9: sticky flag holds unless cleared
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stickyFlag && !(cfgWe && cfgAddr == 3'd0 && cfgBe[0] && cfgWdata[0])) |=> stickyFlag);

  // R9: flag rises only with the forced end of a cycle
  a_r9_sticky_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyFlag) |-> reqAck);

  // R5: low-lane-only write keeps the upper lane of a timing register
  a_r5_lane_keep: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgBe == 2'b01 && cfgAddr >= 3'd1 && cfgAddr <= 3'd5) |=>
      ((cfgAddr != $past(cfgAddr)) || (cfgRdata[CFG_W-1:HALF] == $past(cfgRdata[CFG_W-1:HALF]))));

endmodule

bind pio_timing_gen pio_timing_chk #(.CFG_W(2*FIELD_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgBe(cfgBe),
  .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqAck(reqAck),
  .ataRdN(ataRdN), .ataWrN(ataWrN), .stickyFlag(stickyFlag),
  .enFlag(enFlag), .busy(busy)
);

// File: tb/pio_timing_gen_test.sv
`timescale 1ns/1ps
module pio_timing_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS_CFG = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [1:0]  cfgBe = '0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        reqValid = 1'b0, reqDev = 1'b0, reqIsData = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        reqAck;
  logic [15:0] reqRdata;
  logic        ataRdN, ataWrN, ataDoe;
  logic        ataIordy = 1'b1;
  logic [15:0] ataDin = '0;
  logic [15:0] ataDout;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // measurement results
  int mStart, mEnd, mSecond, mAck, mAckCnt, mWrong, mDoeBad;
  logic [15:0] mRdata, mDout;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_timing_gen #(.CLK_NS(CLK_NS_CFG)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid), .reqDev(reqDev),
    .reqIsData(reqIsData), .reqWrite(reqWrite), .reqWdata(reqWdata), .reqAck(reqAck),
    .reqRdata(reqRdata), .ataRdN(ataRdN), .ataWrN(ataWrN), .ataIordy(ataIordy),
    .ataDin(ataDin), .ataDout(ataDout), .ataDoe(ataDoe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic logic [15:0] lanes(input bit dev, input int sel, input int oth);
    return dev ? {8'(sel), 8'(oth)} : {8'(oth), 8'(sel)};
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d; cfgBe = be;
    @(negedge clk);
    cfgWe = 1'b0; cfgBe = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
  endtask

  // One access (or two back to back). Starts and ends at a negedge.
  task automatic runAccess(input bit dev, input bit isData, input bit wr,
                           input logic [15:0] wdata, input logic [15:0] din,
                           input bit backToBack, input int lowStart, input int lowLen,
                           input int clearAt);
    int t;
    bit on, wrong;
    mStart = -1; mEnd = -1; mSecond = -1; mAck = -1; mAckCnt = 0; mWrong = 0; mDoeBad = 0;
    mRdata = '0; mDout = '0;
    t = 0;
    reqDev = dev; reqIsData = isData; reqWrite = wr; reqWdata = wdata; ataDin = din;
    reqValid = 1'b1;
    ataIordy = !(t >= lowStart && (lowLen < 0 || t < lowStart + lowLen));
    while (t < 400) begin
      @(negedge clk);
      t++;
      if (cfgWe) begin cfgWe = 1'b0; cfgBe = '0; end
      on    = wr ? !ataWrN : !ataRdN;
      wrong = wr ? !ataRdN : !ataWrN;
      if (wrong) mWrong++;
      if (on && wr && !ataDoe) mDoeBad++;
      if (reqAck) begin
        mAckCnt++;
        if (mAck < 0) begin mAck = t; mRdata = reqRdata; end
      end
      if (on && mStart < 0) begin
        mStart = t; mDout = ataDout;
        if (!backToBack) reqValid = 1'b0;
      end
      if (!on && mStart >= 0 && mEnd < 0) begin
        mEnd = t; ataDin = ~din;
      end
      if (on && mEnd >= 0 && mSecond < 0) begin
        mSecond = t; reqValid = 1'b0;
      end
      ataIordy = !(t >= lowStart && (lowLen < 0 || t < lowStart + lowLen));
      if (t == clearAt) begin
        cfgWe = 1'b1; cfgAddr = 3'd0; cfgWdata = 16'h8001; cfgBe = 2'b11;
      end
      if (backToBack ? (mSecond >= 0) : (mEnd >= 0 && mAck >= 0)) break;
    end
    reqValid = 1'b0;
    ataIordy = 1'b1;
    if (cfgWe) begin @(negedge clk); cfgWe = 1'b0; cfgBe = '0; end
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int dStbE, dRcvE, tStbE, tRcvE;
    int seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: reset state
    dStbE = cdiv(165, CLK_NS_CFG) - 1;
    dRcvE = cdiv(600, CLK_NS_CFG) - cdiv(165, CLK_NS_CFG) - 1;
    tStbE = cdiv(290, CLK_NS_CFG) - 1;
    tRcvE = cdiv(600, CLK_NS_CFG) - cdiv(290, CLK_NS_CFG) - 1;
    readReg(3'd0, rd); chk(rd == 16'h0000, "R6 ctrl reset", rd, 0);
    readReg(3'd1, rd); chk(rd == {8'(dStbE), 8'(dStbE)}, "R6 data strobe reset", rd, {8'(dStbE), 8'(dStbE)});
    readReg(3'd2, rd); chk(rd == {8'(dRcvE), 8'(dRcvE)}, "R6 data recovery reset", rd, {8'(dRcvE), 8'(dRcvE)});
    readReg(3'd3, rd); chk(rd == {8'(tStbE), 8'(tStbE)}, "R6 taskfile strobe reset", rd, {8'(tStbE), 8'(tStbE)});
    readReg(3'd4, rd); chk(rd == {8'(tRcvE), 8'(tRcvE)}, "R6 taskfile recovery reset", rd, {8'(tRcvE), 8'(tRcvE)});
    readReg(3'd5, rd); chk(rd == 16'hFFFF, "R6 timeout reset", rd, 16'hFFFF);
    chk(ataRdN && ataWrN && !reqAck, "R6 strobes idle at reset", {ataRdN, ataWrN, reqAck}, 3'b110);

    // R7: disabled, request ignored
    reqValid = 1'b1;
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (!ataRdN || !ataWrN || reqAck) seen++;
    end
    reqValid = 1'b0;
    chk(seen == 0, "R7 no cycle while disabled", seen, 0);

    // R5: byte-lane writes
    writeReg(3'd1, 16'hAB55, 2'b01);
    readReg(3'd1, rd); chk(rd == {8'(dStbE), 8'h55}, "R5 low lane write", rd, {8'(dStbE), 8'h55});
    writeReg(3'd1, 16'h3CC3, 2'b10);
    readReg(3'd1, rd); chk(rd == 16'h3C55, "R5 high lane write", rd, 16'h3C55);
    writeReg(3'd0, 16'h8000, 2'b01);
    readReg(3'd0, rd); chk(rd == 16'h0000, "R5 enable lane masked", rd, 0);

    writeReg(3'd0, 16'h8000, 2'b10);
    readReg(3'd0, rd); chk(rd == 16'h8000, "R7 enable set", rd, 16'h8000);
    writeReg(3'd5, 16'd20, 2'b11);

    // R1 R2 R3 R4 R10 R11: sweep
    for (int dev = 0; dev < 2; dev++) begin
      for (int isD = 0; isD < 2; isD++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int ni = 0; ni < 3; ni++) begin
            for (int mi = 0; mi < 3; mi++) begin
              int n, m;
              logic [15:0] wv, dv;
              n = (ni == 0) ? 0 : (ni == 1) ? 2 : 5;
              m = (mi == 0) ? 0 : (mi == 1) ? 1 : 4;
              wv = 16'(16'h1200 + dev * 64 + isD * 16 + n * 4 + m);
              dv = 16'(16'hC000 ^ (dev * 256 + isD * 32 + n * 8 + m));
              writeReg(3'd1, isD ? lanes(dev[0], n, n + 2) : lanes(dev[0], n + 4, n + 4), 2'b11);
              writeReg(3'd2, isD ? lanes(dev[0], m, m + 3) : lanes(dev[0], m + 5, m + 5), 2'b11);
              writeReg(3'd3, isD ? lanes(dev[0], n + 4, n + 4) : lanes(dev[0], n, n + 2), 2'b11);
              writeReg(3'd4, isD ? lanes(dev[0], m + 5, m + 5) : lanes(dev[0], m, m + 3), 2'b11);
              runAccess(dev[0], isD[0], wr[0], wv, dv, 1'b1, 1000, 0, -1);
              chk(mStart == 1, "R2 strobe starts after accept", mStart, 1);
              chk(mEnd - mStart == n + 1, "R2 R1 R4 strobe width", mEnd - mStart, n + 1);
              chk(mSecond - mStart == n + m + 2, "R3 back-to-back spacing", mSecond - mStart, n + m + 2);
              chk(mAck == mEnd, "R10 ack clock", mAck, mEnd);
              chk(mWrong == 0, "R11 opposite strobe", mWrong, 0);
              if (wr != 0) begin
                chk(mDout == wv, "R11 write data", mDout, wv);
                chk(mDoeBad == 0, "R11 output enable", mDoeBad, 0);
              end else begin
                chk(mRdata == dv, "R10 read capture", mRdata, dv);
              end
            end
          end
        end
      end
    end

    // R10: single ack per access
    writeReg(3'd1, 16'h0303, 2'b11);
    writeReg(3'd2, 16'h0202, 2'b11);
    runAccess(1'b0, 1'b1, 1'b0, 16'h0, 16'h5A5A, 1'b0, 1000, 0, -1);
    chk(mAckCnt == 1, "R10 one ack", mAckCnt, 1);

    // R8: ready stretch, also low while idle beforehand
    for (int k = 1; k <= 7; k += 3) begin
      ataIordy = 1'b0;
      repeat (3) @(negedge clk);
      chk(ataRdN && ataWrN, "R8 idle ignores ready", {ataRdN, ataWrN}, 2'b11);
      ataIordy = 1'b1;
      runAccess(1'b1, 1'b1, 1'b0, 16'h0, 16'h1234, 1'b0, 1, k, -1);
      chk(mEnd - mStart == 3 + 1 + k, "R8 stretched width", mEnd - mStart, 3 + 1 + k);
    end

    // R9: timeout, clear coinciding with the forced end
    writeReg(3'd5, 16'd3, 2'b11);
    runAccess(1'b0, 1'b1, 1'b1, 16'hBEEF, 16'h0, 1'b0, 0, -1, 4);
    chk(mEnd - mStart == 4, "R9 timeout width", mEnd - mStart, 4);
    chk(mAck == mEnd, "R9 R10 ack on timeout", mAck, mEnd);
    readReg(3'd0, rd); chk(rd[0] == 1'b1, "R9 set wins over clear", rd[0], 1);
    writeReg(3'd0, 16'h8001, 2'b11);
    readReg(3'd0, rd); chk(rd == 16'h8000, "R9 clear", rd, 16'h8000);

    // R9: timeout, clear later
    writeReg(3'd5, 16'd6, 2'b11);
    runAccess(1'b1, 1'b0, 1'b0, 16'h0, 16'h0F0F, 1'b0, 0, -1, -1);
    chk(mEnd - mStart == 7, "R9 timeout width T6", mEnd - mStart, 7);
    readReg(3'd0, rd); chk(rd[0] == 1'b1, "R9 sticky set", rd[0], 1);
    writeReg(3'd0, 16'h8000, 2'b11);
    readReg(3'd0, rd); chk(rd[0] == 1'b1, "R9 write of zero keeps flag", rd[0], 1);
    writeReg(3'd0, 16'h8001, 2'b11);
    readReg(3'd0, rd); chk(rd[0] == 1'b0, "R9 cleared", rd[0], 0);

    // R7: disable again
    writeReg(3'd0, 16'h0000, 2'b10);
    reqValid = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (!ataRdN || !ataWrN) seen++;
    end
    reqValid = 1'b0;
    chk(seen == 0, "R7 disabled after clear", seen, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule